// File: doc/BRIEF.md
# HDLC Transmit Serializer with Selectable FCS and RTS Control

This block turns a stream of frame bytes into a serial HDLC line signal. Each frame goes out as an opening 0x7E flag, then the payload bytes, then a frame check sequence (FCS), then a closing 0x7E flag. Every byte is sent least significant bit first. The serializer moves forward only on a serial clock enable strobe. In bit mode it sends one bit per strobe. In nibble mode it sends `SER_W` bits per strobe.

At the start of each frame a two-bit selector chooses the FCS width: a 16-bit CRC or a 32-bit CRC. A request-to-send output frames the transmission. It rises one serial strobe before the first flag bit. It falls at a time that depends on the mode once the closing flag is complete.

Frame bytes enter through a one-byte holding register with a valid/ready handshake and a last-byte marker. The upstream source offers the next byte as soon as the previous byte has been taken.

Top module: `hdlc_fcs_serializer`

## Requirements
- R1: After reset, `rts` is 0, every `txd` line is 1, `in_ready` is 1 and `cfg_err` is 0.
- R2: A frame is sent as 0x7E, the payload bytes in arrival order, the FCS bytes, then 0x7E. Each byte is sent bit 0 first. No bits are inserted.
- R3: In bit mode (`nib_mode`=0 at frame start), each serial strobe sends one bit on `txd[0]`, and `txd[SER_W-1:1]` stay at 1. `txd` changes only on clock edges where `sclk_en` is high.
- R4: In nibble mode (`nib_mode`=1 at frame start), each serial strobe sends `SER_W` bits. `txd[0]` carries the earliest of those bits.
- R5: With `crc_sel`=00, the FCS uses the polynomial x^16+x^12+x^5+1. The register is preset to all ones and processed LSB-first. Two bytes are sent: the complemented register, low byte first. For the payload "123456789", the FCS bytes are 0x6E then 0x90.
- R6: With `crc_sel`=10, the FCS uses the 32-bit polynomial x^32+x^26+x^23+x^22+x^16+x^12+x^11+x^10+x^8+x^7+x^5+x^4+x^2+x+1, with the same preset, complement and byte order. For "123456789", the FCS bytes are 0x26, 0x39, 0xF4, 0xCB.
- R7: `crc_sel` values 01 and 11 are reserved. They produce the 16-bit FCS and set `cfg_err`, which stays at 1 until reset.
- R8: `nib_mode` and `crc_sel` are sampled only at frame start. Changing them during a frame does not alter that frame.
- R9: A frame starts on a serial strobe when the block is idle, `rts` is low and a byte is waiting. `rts` rises on that strobe. The first flag bit goes out on the next strobe.
- R10: In bit mode, `rts` falls on the first serial strobe after the one that sent the last closing-flag bit.
- R11: In nibble mode, `rts` falls exactly `RTS_LAG` clocks (1 to 5) after the strobe that sent the last closing-flag nibble.
- R12: `in_ready` is high exactly when the holding register is empty. A byte is captured on a clock where `in_valid` and `in_ready` are both high. `in_last` marks the final payload byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_en | input | 1 | One-clock strobe marking the active serial clock edge |
| nib_mode | input | 1 | 0 for bit mode, 1 for nibble mode; sampled at frame start |
| crc_sel | input | 2 | FCS select: 00 for 16-bit, 10 for 32-bit, other values reserved |
| in_valid | input | 1 | Payload byte valid |
| in_ready | output | 1 | Holding register empty |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | Marks the final payload byte of a frame |
| txd | output | SER_W | Serial data lines |
| rts | output | 1 | Request to send |
| cfg_err | output | 1 | Sticky flag for a reserved CRC select value |

## Verification
The hardest behaviour to reach from the ports is the end of a nibble-mode frame. There, `rts` must fall a fixed number of system clocks after the last nibble and before the next serial strobe, while the configuration inputs have already been changed to different values. The bench logs every strobe with its clock tick and `rts` value, and records the tick at which `rts` falls. It flips `nib_mode` and `crc_sel` in the middle of every frame. From the log it rebuilds the bit stream, decodes the FCS, and measures the fall delay against the mode that was latched at frame start.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_OPEN,
      PH_DATA,
      PH_FCS,
      PH_CLOSE
   } tx_phase_t;

   localparam logic [7:0]  FLAG_BYTE = 8'h7E;
   // bit-reversed generator constants for LSB-first processing
   localparam logic [31:0] POLY16_R  = 32'h0000_8408;
   localparam logic [31:0] POLY32_R  = 32'hEDB8_8320;
   localparam logic [31:0] PRESET16  = 32'h0000_FFFF;
   localparam logic [31:0] PRESET32  = 32'hFFFF_FFFF;

endpackage

// File: rtl/hdlc_crc_core.sv
module hdlc_crc_core #(
   parameter int SER_W = 4
) (
   input  logic [31:0]      crc_i,
   input  logic [SER_W-1:0] bits_i,
   input  logic             nib_i,
   input  logic             wide_i,
   output logic [31:0]      crc_o
);
   import hdlc_tx_pkg::*;

   logic [31:0] poly;
   assign poly = wide_i ? POLY32_R : POLY16_R;

   // lane 0 always folds; remaining lanes fold only in nibble mode
   always_comb begin
      logic [31:0] acc;
      logic        fb;
      acc = crc_i;
      for (int i = 0; i < SER_W; i++) begin
         if (i == 0 || nib_i) begin
            fb  = acc[0] ^ bits_i[i];
            acc = (acc >> 1) ^ (fb ? poly : 32'h0);
         end
      end
      crc_o = acc;
   end

endmodule

// File: rtl/hdlc_tx_hold.sv
module hdlc_tx_hold (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_valid,
   input  logic [7:0] in_data,
   input  logic       in_last,
   output logic       in_ready,
   input  logic       take_i,
   output logic       full_o,
   output logic [7:0] data_o,
   output logic       last_o
);
   assign in_ready = !full_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_o <= 1'b0;
         data_o <= '0;
         last_o <= 1'b0;
      end else if (in_valid && in_ready) begin
         full_o <= 1'b1;
         data_o <= in_data;
         last_o <= in_last;
      end else if (take_i) begin
         full_o <= 1'b0;
      end
   end

   AST_TAKE_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      take_i |-> full_o);                                           // R12
   AST_CAPTURE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !in_ready);                        // R12

endmodule

// File: rtl/hdlc_rts_ctl.sv
module hdlc_rts_ctl #(
   parameter int RTS_LAG = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_en,
   input  logic start_i,
   input  logic done_i,
   input  logic nib_i,
   output logic rts_o
);
   localparam int CW = $clog2(RTS_LAG + 1);
   localparam logic [CW-1:0] LAG_END = CW'(RTS_LAG - 1);

   if (RTS_LAG < 1 || RTS_LAG > 5) begin : g_bad_lag
      $error("RTS_LAG must lie in 1..5");
   end

   logic          pend;
   logic [CW-1:0] cnt;
   logic          drop;

   assign drop = nib_i ? (cnt == LAG_END) : sclk_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rts_o <= 1'b0;
         pend  <= 1'b0;
         cnt   <= '0;
      end else if (start_i) begin
         rts_o <= 1'b1;
      end else if (done_i) begin
         pend  <= 1'b1;
         cnt   <= '0;
      end else if (pend) begin
         if (drop) begin
            rts_o <= 1'b0;
            pend  <= 1'b0;
         end else if (nib_i) begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   AST_BIT_FALL_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(rts_o) && !nib_i) |-> $past(sclk_en));                 // R10
   AST_NO_FALL_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done_i |=> rts_o);                                            // R11

endmodule

// File: rtl/hdlc_fcs_serializer.sv
module hdlc_fcs_serializer #(
   parameter int SER_W   = 4,
   parameter int RTS_LAG = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sclk_en,
   input  logic             nib_mode,
   input  logic [1:0]       crc_sel,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [7:0]       in_data,
   input  logic             in_last,
   output logic [SER_W-1:0] txd,
   output logic             rts,
   output logic             cfg_err
);
   import hdlc_tx_pkg::*;

   localparam logic [3:0] BYTE_BITS = 4'd8;
   localparam logic [3:0] NIB_STEP  = 4'(SER_W);

   if (SER_W < 2 || SER_W > 8 || (8 % SER_W) != 0) begin : g_bad_w
      $error("SER_W must divide 8 and be at least 2");
   end

   tx_phase_t   phase;
   logic [7:0]  sh;
   logic [3:0]  left;
   logic        last_q;
   logic [1:0]  fcs_idx;
   logic [31:0] crc;
   logic        nib_q;
   logic        wide_q;

   logic        hold_full;
   logic [7:0]  hold_data;
   logic        hold_last;
   logic        take;

   logic [31:0]      crc_adv;
   logic [31:0]      crc_inv;
   logic [SER_W-1:0] txd_nxt;
   logic [3:0]       step;
   logic [3:0]       left_after;
   logic [7:0]       sh_shift;
   logic [1:0]       fcs_top;
   logic [1:0]       fcs_next;
   logic             emit;
   logic             byte_end;
   logic             refill;
   logic             start;
   logic             done;

   hdlc_tx_hold u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_data  (in_data),
      .in_last  (in_last),
      .in_ready (in_ready),
      .take_i   (take),
      .full_o   (hold_full),
      .data_o   (hold_data),
      .last_o   (hold_last)
   );

   hdlc_crc_core #(.SER_W(SER_W)) u_crc (
      .crc_i  (crc),
      .bits_i (sh[SER_W-1:0]),
      .nib_i  (nib_q),
      .wide_i (wide_q),
      .crc_o  (crc_adv)
   );

   hdlc_rts_ctl #(.RTS_LAG(RTS_LAG)) u_rts (
      .clk     (clk),
      .rst_n   (rst_n),
      .sclk_en (sclk_en),
      .start_i (start),
      .done_i  (done),
      .nib_i   (nib_q),
      .rts_o   (rts)
   );

   // lane mapping: nibble mode uses all lanes, bit mode parks upper lanes high
   for (genvar g = 0; g < SER_W; g++) begin : g_lane
      if (g == 0) begin : g_first
         assign txd_nxt[g] = sh[0];
      end else begin : g_upper
         assign txd_nxt[g] = nib_q ? sh[g] : 1'b1;
      end
   end

   assign step       = nib_q ? NIB_STEP : 4'd1;
   assign left_after = left - step;
   assign sh_shift   = nib_q ? (sh >> SER_W) : (sh >> 1);
   assign crc_inv    = ~crc;
   assign fcs_top    = wide_q ? 2'd3 : 2'd1;
   assign fcs_next   = fcs_idx + 2'd1;

   assign emit     = sclk_en && (phase != PH_IDLE) && (left != 4'd0);
   assign byte_end = emit && (left_after == 4'd0);
   assign refill   = (phase == PH_DATA) && (left == 4'd0) && hold_full;
   assign start    = sclk_en && (phase == PH_IDLE) && hold_full && !rts;
   assign done     = byte_end && (phase == PH_CLOSE);
   assign take     = refill ||
                     (byte_end && hold_full &&
                      (phase == PH_OPEN || (phase == PH_DATA && !last_q)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         sh      <= '0;
         left    <= '0;
         last_q  <= 1'b0;
         fcs_idx <= '0;
         crc     <= '0;
         nib_q   <= 1'b0;
         wide_q  <= 1'b0;
         cfg_err <= 1'b0;
         txd     <= '1;
      end else if (start) begin
         phase  <= PH_OPEN;
         sh     <= FLAG_BYTE;
         left   <= BYTE_BITS;
         nib_q  <= nib_mode;
         wide_q <= (crc_sel == 2'b10);
         crc    <= (crc_sel == 2'b10) ? PRESET32 : PRESET16;
         if (crc_sel[0]) cfg_err <= 1'b1;
      end else if (emit) begin
         txd <= txd_nxt;
         if (phase == PH_DATA) crc <= crc_adv;
         if (!byte_end) begin
            sh   <= sh_shift;
            left <= left_after;
         end else begin
            unique case (phase)
               PH_OPEN: begin
                  phase  <= PH_DATA;
                  sh     <= hold_data;
                  last_q <= hold_last;
                  left   <= hold_full ? BYTE_BITS : 4'd0;
               end
               PH_DATA: begin
                  if (last_q) begin
                     phase   <= PH_FCS;
                     sh      <= ~crc_adv[7:0];
                     fcs_idx <= 2'd0;
                     left    <= BYTE_BITS;
                  end else begin
                     sh     <= hold_data;
                     last_q <= hold_last;
                     left   <= hold_full ? BYTE_BITS : 4'd0;
                  end
               end
               PH_FCS: begin
                  left <= BYTE_BITS;
                  if (fcs_idx == fcs_top) begin
                     phase <= PH_CLOSE;
                     sh    <= FLAG_BYTE;
                  end else begin
                     fcs_idx <= fcs_next;
                     sh      <= crc_inv[{fcs_next, 3'b000} +: 8];
                  end
               end
               PH_CLOSE: begin
                  phase <= PH_IDLE;
                  left  <= 4'd0;
               end
               default: ;
            endcase
         end
      end else if (refill) begin
         sh     <= hold_data;
         last_q <= hold_last;
         left   <= BYTE_BITS;
      end
   end

   AST_RTS_SPANS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_IDLE) |-> rts);                                  // R9
   AST_TXD_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !sclk_en |=> $stable(txd));                                   // R3
   AST_CFG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |=> cfg_err);                                         // R7
   AST_FCS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_FCS) |=> $stable(crc));                          // R5
   AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_IDLE && !start) |=> $stable(nib_q) && $stable(wide_q)); // R8

endmodule

// File: tb/sim_hdlc_fcs_serializer.sv
module sim_hdlc_fcs_serializer;
   localparam int SER_W   = 4;
   localparam int RTS_LAG = 3;
   localparam int DIV     = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sclk_en = 1'b0;
   logic       nib_mode = 1'b0;
   logic [1:0] crc_sel = 2'b00;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic [7:0] in_data = '0;
   logic       in_last = 1'b0;
   logic [SER_W-1:0] txd;
   logic       rts;
   logic       cfg_err;

   int checks = 0;
   int errors = 0;

   hdlc_fcs_serializer #(.SER_W(SER_W), .RTS_LAG(RTS_LAG)) u0 (
      .clk(clk), .rst_n(rst_n), .sclk_en(sclk_en), .nib_mode(nib_mode),
      .crc_sel(crc_sel), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .in_last(in_last), .txd(txd), .rts(rts),
      .cfg_err(cfg_err)
   );

   always #4 clk = ~clk;

   // strobe log
   logic       log_rts  [0:511];
   logic [3:0] log_txd  [0:511];
   int         log_tick [0:511];
   int         nlog = 0;
   bit         logging = 0;
   int         tick = 0;
   int         dcnt = 0;
   int         fall_tick = -1;
   logic       rts_prev = 1'b0;

   always @(negedge clk) begin
      tick = tick + 1;
      if (logging && sclk_en && nlog < 512) begin
         log_rts[nlog]  = rts;
         log_txd[nlog]  = txd;
         log_tick[nlog] = tick;
         nlog = nlog + 1;
      end
      if (logging && rts_prev && !rts && fall_tick < 0) fall_tick = tick;
      rts_prev = rts;
      dcnt = (dcnt + 1) % DIV;
      sclk_en = (dcnt == 0);
   end

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] crc_ref(input bit wide, input logic [7:0] b);
      logic [31:0] c;
      c = wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
      for (int i = 0; i < 8; i++) begin
         logic fb;
         fb = c[0] ^ b[i];
         c  = c >> 1;
         if (fb) c = c ^ (wide ? 32'hEDB8_8320 : 32'h0000_8408);
      end
      return ~c & (wide ? 32'hFFFF_FFFF : 32'h0000_FFFF);
   endfunction

   task automatic run_frame(input bit nib, input logic [1:0] sel, input int nb,
                            input logic [7:0] base, input bit exp_err,
                            input logic [31:0] exp_fcs);
      logic [7:0] exp_b [0:15];
      logic [7:0] got   [0:15];
      int nf, nbyt, w, s0, e, bad, bad_at, fbad;
      bit wide, upper_ok;
      wide = (sel == 2'b10);
      nf   = wide ? 4 : 2;
      nbyt = nb + nf + 2;
      w    = nib ? SER_W : 1;
      exp_b[0] = 8'h7E;
      for (int i = 0; i < nb; i++) exp_b[1+i] = base + 8'(i);
      for (int k = 0; k < nf; k++) exp_b[1+nb+k] = exp_fcs[8*k +: 8];
      exp_b[nbyt-1] = 8'h7E;

      @(negedge clk);
      nib_mode = nib;
      crc_sel  = sel;
      nlog = 0; fall_tick = -1; logging = 1;
      for (int i = 0; i < nb; i++) begin
         in_valid = 1'b1;
         in_data  = base + 8'(i);
         in_last  = (i == nb - 1);
         while (!in_ready) @(negedge clk);
         @(negedge clk);
         if (i == 0) check(!in_ready, "R12", "ready after capture", in_ready, 0);
         if (i == 1) begin  // R8: configuration flipped mid-frame
            nib_mode = ~nib;
            crc_sel  = ~sel;
         end
      end
      in_valid = 1'b0;
      in_last  = 1'b0;
      while (fall_tick < 0) @(negedge clk);
      repeat (2) @(negedge clk);
      logging = 0;

      s0 = -1;
      for (int k = 0; k < nlog; k++) if (s0 < 0 && log_rts[k]) s0 = k;
      for (int j = 0; j < 8 * nbyt; j++) begin
         int s;
         s = s0 + 1 + j / w;
         got[j/8][j%8] = nib ? log_txd[s][j%SER_W] : log_txd[s][0];
      end
      upper_ok = 1;
      for (int k = s0 + 1; k <= s0 + (8 * nbyt) / w; k++)
         if (!nib && log_txd[k][3:1] != 3'b111) upper_ok = 0;
      bad = 0; bad_at = 0; fbad = 0;
      for (int k = 0; k < nbyt; k++) if (got[k] != exp_b[k]) begin
         if (bad == 0) bad_at = k;
         bad++;
         if (k > nb && k < nbyt - 1) fbad++;
      end
      e = s0 + (8 * nbyt) / w;

      check(got[0] == 8'h7E, "R9", "first byte after rts rise", got[0], 8'h7E);
      check(bad == 0, nib ? "R2/R4/R8" : "R2/R3/R8", "stream byte",
            got[bad_at], exp_b[bad_at]);
      check(fbad == 0, exp_err ? "R7" : (wide ? "R6" : "R5"), "fcs bytes",
            {got[nb+4], got[nb+3], got[nb+2], got[nb+1]}, exp_fcs);
      check(fall_tick - log_tick[e] == (nib ? RTS_LAG : DIV),
            nib ? "R11" : "R10", "rts fall delay",
            fall_tick - log_tick[e], nib ? RTS_LAG : DIV);
      check(cfg_err == exp_err, "R7", "cfg_err", cfg_err, exp_err);
      if (!nib) check(upper_ok, "R3", "upper lanes high", upper_ok, 1);
   endtask

   // {nib, sel[1:0], exp_err, fcs[31:0]}
   localparam logic [35:0] VEC [0:6] = '{
      {1'b0, 2'b00, 1'b0, 32'h0000_906E},
      {1'b0, 2'b10, 1'b0, 32'hCBF4_3926},
      {1'b1, 2'b00, 1'b0, 32'h0000_906E},
      {1'b1, 2'b10, 1'b0, 32'hCBF4_3926},
      {1'b1, 2'b11, 1'b1, 32'h0000_906E},
      {1'b0, 2'b01, 1'b1, 32'h0000_906E},
      {1'b1, 2'b10, 1'b1, 32'hCBF4_3926}
   };

   task automatic summary;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      summary();
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check(rts == 1'b0, "R1", "rts", rts, 0);
      check(txd == '1, "R1", "txd", txd, 4'hF);
      check(in_ready == 1'b1, "R1", "in_ready", in_ready, 1);
      check(cfg_err == 1'b0, "R1", "cfg_err", cfg_err, 0);

      for (int v = 0; v < 7; v++)
         run_frame(VEC[v][35], VEC[v][34:33], 9, 8'h31, VEC[v][32], VEC[v][31:0]);

      // R7: sticky flag clears only through reset
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(cfg_err == 1'b0, "R7", "cfg_err after reset", cfg_err, 0);
      check(rts == 1'b0, "R1", "rts after reset", rts, 0);

      // single-byte frames, expected FCS from the bench model
      run_frame(1'b0, 2'b10, 1, 8'hA5, 1'b0, crc_ref(1'b1, 8'hA5));
      run_frame(1'b1, 2'b00, 1, 8'h00, 1'b0, crc_ref(1'b0, 8'h00));

      summary();
      $finish;
   end

endmodule